// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver

This block sits between a CPU core and its interrupt sources. It gathers peripheral request lines, one per slot of a 64-entry, two-byte vector table at 0xFF80–0xFFFF. It also conditions the external IRQ and XIRQ pins and honours the CPU's I and X mask bits. It tells the core whether an interrupt is pending and gives the low byte of the vector address that wins arbitration. Fixed priority follows the vector address, so higher addresses win. Software can lift any one implemented maskable source to the top by writing that source's vector low byte into a high-priority register.

The IRQ pin passes through a write-once control register. That register connects or disconnects the pin and selects level or falling-edge sensing. In edge mode the request is held in a latch until the core acknowledges the IRQ vector. While the core asserts `ack`, the reported vector stays frozen so that the fetch reads a consistent address.

Peripheral lines occupy slots 0–56 (vector low byte 0x80 + 2·slot). Slot 57 (0xF2) belongs to the IRQ pin, and XIRQ reports 0xF4. Stacking and the vector fetch itself happen in the core.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `int_pending` is 0 and `vec_lo` is 0x00. The high-priority register holds 0xF2, and the IRQ control holds enabled, level mode.
- R2: Among unmasked maskable requests, the highest slot wins, and `vec_lo` = 0x80 + 2·slot. With no request pending, `vec_lo` is 0x00.
- R3: While `i_mask` is 1, no peripheral or IRQ request raises `int_pending` or changes `vec_lo`.
- R4: A request on a slot whose bit in `IMPL` is 0 (slots 3 and 10 by default) is ignored.
- R5: A write with `wr_sel`=1 and `i_mask`=1 stores `wr_data[7:1]` as the promoted vector. `wr_data[0]` is ignored. A pending promoted source beats every other maskable request.
- R6: A write to the high-priority register while `i_mask` is 0 has no effect.
- R7: If the written value (bit 0 cleared) is below 0x80, above 0xF2, or names an unimplemented slot, the register takes 0xF2.
- R8: An XIRQ request (pin low) is masked while `x_mask` is 1. Once `x_mask` has been seen at 0 after reset, XIRQ stays unmasked. When unmasked, it reports 0xF4 ahead of all maskable requests and ignores `i_mask`.
- R9: IRQ control bit 0 (written with `wr_sel`=0) enables the IRQ pin. When it is 0, the pin never raises a request.
- R10: IRQ control bit 1 selects edge mode. In edge mode a falling edge sets a latch, which clears on the first `ack` cycle while 0xF2 wins. In level mode the request follows the low pin directly.
- R11: The IRQ control register accepts only the first write after reset.
- R12: From the first cycle of `ack` until its release, `vec_lo` keeps the value it had in that first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 57 | Peripheral request lines, slot n at bit n |
| i_mask | input | 1 | CPU I mask bit |
| x_mask | input | 1 | CPU X mask bit |
| irq_pin_n | input | 1 | IRQ pin, active low |
| xirq_pin_n | input | 1 | XIRQ pin, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: IRQ control, 1: high-priority register |
| wr_data | input | 8 | Write data |
| ack | input | 1 | CPU interrupt acknowledge |
| int_pending | output | 1 | Unmasked interrupt present |
| vec_lo | output | 8 | Low byte of the winning vector address |

## Verification
A corrupt high-priority register shows at once as the wrong winner the first time `i_mask` drops with every line requesting. Sweeping all 256 write values therefore exposes any defect in range or implementation filtering within one cycle of each write. A stuck or missed IRQ edge latch shows one edge after the pin falls, or on the cycle after `ack`. A broken hold register shows as a change of `vec_lo` during a long acknowledge while a higher request arrives. A leaking XIRQ sticky bit shows only after `x_mask` returns to 1.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int          NPER = 57,
  parameter logic [56:0] IMPL = 57'h1FF_FFFF_FFFF_FBF7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPER-1:0] req_i,
  input  logic            i_mask,
  input  logic            x_mask,
  input  logic            irq_pin_n,
  input  logic            xirq_pin_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [7:0]      wr_data,
  input  logic            ack,
  output logic            int_pending,
  output logic [7:0]      vec_lo
);
  localparam int          SLOTS    = 64;
  localparam int          IRQ_SLOT = NPER;
  localparam logic [7:0]  IRQ_VEC  = 8'h80 + 8'(2 * IRQ_SLOT);
  localparam logic [7:0]  XIRQ_VEC = IRQ_VEC + 8'd2;
  localparam logic [SLOTS-1:0] IMPL_ALL = {{(SLOTS-NPER-1){1'b0}}, 1'b1, IMPL};

  logic [1:0] ctrl_q;
  logic       ctrl_locked;
  logic [6:0] hp_q;
  logic       irq_prev, irq_lat, x_armed, ack_d;
  logic [7:0] held;

  logic [SLOTS-1:0] mreq;
  logic [5:0]       top_slot;
  logic             any_req;
  logic [7:0]       comb_vec;

  wire [7:0] wr_vec   = {wr_data[7:1], 1'b0};
  wire       wr_ok    = wr_vec[7] && (wr_vec <= IRQ_VEC) && IMPL_ALL[wr_vec[6:1]];
  wire       irq_fall = irq_prev & ~irq_pin_n;
  wire       irq_req  = ctrl_q[0] & (ctrl_q[1] ? irq_lat : ~irq_pin_n);
  wire       x_open   = ~x_mask | x_armed;
  wire       xirq_hit = ~xirq_pin_n & x_open;
  wire       promo    = mreq[hp_q[5:0]];
  wire       hold     = ack & ack_d;
  wire       ack_rise = ack & ~ack_d;

  always_comb begin
    mreq = '0;
    for (int i = 0; i < NPER; i++) mreq[i] = req_i[i] & IMPL[i];
    mreq[IRQ_SLOT] = irq_req;
    if (i_mask) mreq = '0;
  end

  always_comb begin
    any_req  = 1'b0;
    top_slot = '0;
    for (int i = 0; i < SLOTS; i++)
      if (mreq[i]) begin
        any_req  = 1'b1;
        top_slot = i[5:0];
      end
  end

  always_comb begin
    if (xirq_hit)     comb_vec = XIRQ_VEC;
    else if (promo)   comb_vec = {hp_q, 1'b0};
    else if (any_req) comb_vec = {1'b1, top_slot, 1'b0};
    else              comb_vec = 8'h00;
  end

  assign int_pending = xirq_hit | any_req;
  assign vec_lo      = hold ? held : comb_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= 2'b01;
      ctrl_locked <= 1'b0;
    end else if (wr_en && !wr_sel && !ctrl_locked) begin
      ctrl_q      <= wr_data[1:0];
      ctrl_locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hp_q <= IRQ_VEC[7:1];
    else if (wr_en && wr_sel && i_mask) hp_q <= wr_ok ? wr_vec[7:1] : IRQ_VEC[7:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= 1'b1;
      irq_lat  <= 1'b0;
    end else begin
      irq_prev <= irq_pin_n;
      if (!ctrl_q[1] || !ctrl_q[0]) irq_lat <= 1'b0;
      else if (irq_fall) irq_lat <= 1'b1;
      else if (ack_rise && comb_vec == IRQ_VEC) irq_lat <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_armed <= 1'b0;
      ack_d   <= 1'b0;
      held    <= 8'h00;
    end else begin
      if (!x_mask) x_armed <= 1'b1;
      ack_d <= ack;
      if (ack_rise) held <= comb_vec;
    end
  end

  assert_vec_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_d |-> $stable(vec_lo));
  assert_hp_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && !i_mask |=> $stable(hp_q));
  assert_hp_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hp_q[6] && hp_q <= IRQ_VEC[7:1]);
  assert_ctrl_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_locked |=> $stable(ctrl_q));
  assert_x_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    x_armed |=> x_armed);
  assert_xirq_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xirq_pin_n && x_armed && !hold |-> int_pending && vec_lo == XIRQ_VEC);
  assert_imask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    i_mask && (xirq_pin_n || (x_mask && !x_armed)) |-> !int_pending);
endmodule

// File: tb/test_irq_prio_resolver.sv
`timescale 1ns/1ps
module test_irq_prio_resolver;
  logic        clk = 0, rst_n = 0;
  logic [56:0] req_i = '0;
  logic        i_mask = 1, x_mask = 1, irq_pin_n = 1, xirq_pin_n = 1;
  logic        wr_en = 0, wr_sel = 0, ack = 0;
  logic [7:0]  wr_data = 0;
  logic        int_pending;
  logic [7:0]  vec_lo;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_resolver i_irq_prio_resolver (.*);

  function automatic bit impl(int s);
    return (s < 57) && s != 3 && s != 10;
  endfunction

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_i = '0; i_mask = 1; x_mask = 1; irq_pin_n = 1; xirq_pin_n = 1;
    wr_en = 0; ack = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; step(); wr_en = 0;
  endtask

  initial begin
    #500000;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pending", {7'b0, int_pending}, 8'h00);
    chk("R1 vec", vec_lo, 8'h00);

    i_mask = 0;
    for (int s = 0; s < 57; s++) begin
      req_i = 57'd1 << s; #1;
      chk("R4/R2 single pend", {7'b0, int_pending}, {7'b0, impl(s)});
      chk("R4/R2 single vec", vec_lo, impl(s) ? 8'(8'h80 + 2 * s) : 8'h00);
    end
    for (int s = 0; s < 57; s++) begin
      int w = -1;
      req_i = (57'd2 << s) - 57'd1;
      for (int k = 0; k <= s; k++) if (impl(k)) w = k;
      #1;
      chk("R2 highest", vec_lo, w < 0 ? 8'h00 : 8'(8'h80 + 2 * w));
    end
    req_i = '1; i_mask = 1; #1;
    chk("R3 masked pend", {7'b0, int_pending}, 8'h00);
    chk("R3 masked vec", vec_lo, 8'h00);

    for (int b = 0; b < 256; b++) begin
      logic [7:0] v, e;
      v = 8'(b) & 8'hFE;
      e = (v >= 8'h80 && v <= 8'hF2 && (v == 8'hF2 || impl((v - 8'h80) / 2))) ? v : 8'hF2;
      i_mask = 1; req_i = '1;
      wr(1, 8'(b));
      i_mask = 0; #1;
      chk("R5/R7 promoted", vec_lo, e == 8'hF2 ? 8'hF0 : e);
    end
    i_mask = 1; wr(1, 8'h91);
    i_mask = 0; wr(1, 8'hA0); #1;
    chk("R6 write ignored", vec_lo, 8'h90);
    req_i = 57'h1; #1;
    chk("R5 promoted absent", vec_lo, 8'h80);

    req_i = '0; irq_pin_n = 0; #1;
    chk("R9/R10 level irq", vec_lo, 8'hF2);
    irq_pin_n = 1; #1;
    chk("R10 level follows", {7'b0, int_pending}, 8'h00);

    wr(0, 8'h03);
    irq_pin_n = 0; #1;
    chk("R10 edge before clock", {7'b0, int_pending}, 8'h00);
    step(); irq_pin_n = 1; #1;
    chk("R10 edge latched", vec_lo, 8'hF2);
    irq_pin_n = 0; step();
    ack = 1; step();
    chk("R10 cleared by ack", {7'b0, int_pending}, 8'h00);
    ack = 0; step(); step();
    chk("R10 no re-trigger on low", {7'b0, int_pending}, 8'h00);
    wr(0, 8'h00);
    irq_pin_n = 1; step(); irq_pin_n = 0; step();
    chk("R11 second write ignored", vec_lo, 8'hF2);
    ack = 1; step(); ack = 0; step();

    req_i = 57'd1 << 5; ack = 1; step();
    chk("R12 captured", vec_lo, 8'h8A);
    req_i = (57'd1 << 5) | (57'd1 << 20); step(); step();
    chk("R12 held", vec_lo, 8'h8A);
    ack = 0; step();
    chk("R12 released", vec_lo, 8'hA8);

    do_reset();
    wr(0, 8'h02);
    i_mask = 0; irq_pin_n = 1; step(); irq_pin_n = 0; step(); step();
    chk("R9 disabled irq", {7'b0, int_pending}, 8'h00);
    req_i = 57'd1 << 56; #1;
    chk("R1 default hp", vec_lo, 8'hF0);

    req_i = '1; xirq_pin_n = 0; step();
    chk("R8 xirq masked", vec_lo, 8'hF0);
    x_mask = 0; #1;
    chk("R8 xirq wins", vec_lo, 8'hF4);
    step(); x_mask = 1; i_mask = 1; #1;
    chk("R8 sticky pend", {7'b0, int_pending}, 8'h01);
    chk("R8 sticky vec", vec_lo, 8'hF4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule